// File: doc/BRIEF.md
# In-Order Four-Stage Pipeline Controller

This block sequences a single-issue, in-order core through fetch, decode, issue and execute. An upstream fetch source offers one instruction per cycle on a valid/ready handshake. Each instruction carries a destination register tag and up to `NSRC` source register tags, and each tag has its own enable bit. The handshake cycle itself counts as the fetch stage. Decode, issue and execute are each a register that holds at most one instruction together with its valid bit. A cleared valid bit is an empty slot, called a bubble.

The block checks for a read-after-write hazard at decode only. The instruction in decode waits while any of its enabled source tags equals the enabled destination tag of the valid instruction in issue. When that happens the global `stall` rises. Fetch stops accepting new instructions. Decode keeps its instruction. The instruction in issue still moves on into execute, and issue becomes a bubble. Because execution always takes exactly one cycle, the producer's result is written at the end of its execute cycle. `stall` therefore stays high for one more cycle after the hazard clears, while decode already moves forward. In that extra cycle nothing enters decode. Throughput is one instruction per cycle when no hazard is present.

Each cycle the block reports which stages hold an instruction. When an instruction is in execute, the retire outputs present it together with its destination tag.

Top module: `ioc_pipe_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no stage is occupied, `retire_valid` is 0, `stall` is 0 and `fetch_ready` is 1.
- R2: An instruction accepted in cycle n (`fetch_valid` and `fetch_ready` both high) sits in decode in cycle n+1 and in issue in cycle n+2. In cycle n+3 it is presented on the retire outputs with its instruction word, destination tag and destination enable.
- R3: Independent instructions offered back to back are all accepted in consecutive cycles and retire in consecutive cycles, in the order they were accepted.
- R4: A hazard exists when decode is valid, issue is valid, issue's destination enable is 1, and at least one decode source whose enable is 1 has a tag equal to issue's destination tag. A hazard holds decode for one cycle. Matches against the instruction in execute cause no hazard.
- R5: `fetch_ready` is the inverse of `stall`. `stall` is high in the hazard cycle and in the cycle after it. While `stall` is high, the fetch source keeps offering the same instruction and it is not taken.
- R6: In a hazard cycle, the instruction in issue moves to execute and issue is empty in the next cycle.
- R7: If a producer is accepted in cycle 1, a consumer of its result in cycle 2 and an unrelated instruction is offered from cycle 3, then the producer retires in cycle 4. The consumer sits in decode in cycles 3 and 4 and retires in cycle 6. The third instruction is accepted in cycle 5 and retires in cycle 8.
- R8: `occupancy` bit 0 is the fetch handshake of the current cycle, bit 1 is decode valid, bit 2 is issue valid and bit 3 is execute valid. A cycle with `fetch_valid` low feeds a bubble that moves down the pipe one stage per cycle.
- R9: A consumer separated from its producer by one other instruction causes no stall.
- R10: A tag match causes no stall when the producer's destination enable is 0 or the matching source's enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch source offers an instruction |
| fetch_ready | output | 1 | Block takes the offered instruction this cycle |
| fetch_insn | input | IW | Instruction word |
| fetch_dst | input | RW | Destination register tag |
| fetch_dst_en | input | 1 | Instruction writes `fetch_dst` |
| fetch_src | input | NSRC*RW | Source register tags, source k at bits k*RW upward |
| fetch_src_en | input | NSRC | Per-source read enable, bit k for source k |
| stall | output | 1 | Global front-end freeze |
| occupancy | output | 4 | Per-stage occupancy: fetch, decode, issue, execute from bit 0 |
| retire_valid | output | 1 | An instruction is in execute and retires this cycle |
| retire_insn | output | IW | Instruction word of the retiring instruction |
| retire_dst | output | RW | Destination tag of the retiring instruction |
| retire_dst_en | output | 1 | Retiring instruction writes `retire_dst` |

## Verification
The bench replays the producer, consumer and follower timing. It checks both stalled cycles by occupancy pattern. A design that also compared against execute would hold the consumer a second cycle and retire the follower late. A design that dropped the extra stall cycle would accept the follower one cycle early. The bench also sends adjacent instructions whose tags match but whose destination or source enable is low, and a dependency two instructions apart. A design that ignored the enables, or that compared too many stages, would retire these late. A scoreboard predicts every retire cycle from the hazard rule alone, so a design that drops, duplicates or reorders an instruction, or that fails to drain issue during a stall, shows up as a mismatch in word, tag or cycle.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

   typedef enum int {
      STG_FETCH  = 0,
      STG_DECODE = 1,
      STG_ISSUE  = 2,
      STG_EXEC   = 3
   } stage_e;

   localparam int NUM_STAGES = 4;
   // Fetch is the handshake itself; the remaining stages are registers.
   localparam int NUM_REG_STAGES = NUM_STAGES - 1;

endpackage

// File: rtl/ioc_stage_reg.sv
module ioc_stage_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);

   if (W < 1) begin : g_bad_w
      $error("ioc_stage_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (!hold) begin
         out_vld  <= in_vld;
         out_data <= in_data;
      end
   end

endmodule

// File: rtl/ioc_hazard.sv
module ioc_hazard #(
   parameter int RW   = 5,
   parameter int NSRC = 2
) (
   input  logic               cons_vld,
   input  logic [NSRC*RW-1:0] cons_src,
   input  logic [NSRC-1:0]    cons_src_en,
   input  logic               prod_vld,
   input  logic [RW-1:0]      prod_dst,
   input  logic               prod_dst_en,
   output logic               hit
);

   logic [NSRC-1:0] match;

   for (genvar k = 0; k < NSRC; k++) begin : g_cmp
      assign match[k] = cons_src_en[k] && (cons_src[k*RW +: RW] == prod_dst);
   end

   assign hit = cons_vld && prod_vld && prod_dst_en && (|match);

endmodule

// File: rtl/ioc_stall_ctrl.sv
module ioc_stall_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic hazard,
   output logic dec_hold,
   output logic front_stall
);

   logic tail_q;

   // The producer writes at the end of its execute cycle, so the front end
   // stays frozen for one further cycle after decode is released.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tail_q <= 1'b0;
      else        tail_q <= hazard;
   end

   assign dec_hold    = hazard;
   assign front_stall = hazard | tail_q;

endmodule

// File: rtl/ioc_pipe_ctrl.sv
module ioc_pipe_ctrl
   import ioc_pkg::*;
#(
   parameter int IW   = 32,
   parameter int RW   = 5,
   parameter int NSRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fetch_valid,
   output logic               fetch_ready,
   input  logic [IW-1:0]      fetch_insn,
   input  logic [RW-1:0]      fetch_dst,
   input  logic               fetch_dst_en,
   input  logic [NSRC*RW-1:0] fetch_src,
   input  logic [NSRC-1:0]    fetch_src_en,
   output logic               stall,
   output logic [3:0]         occupancy,
   output logic               retire_valid,
   output logic [IW-1:0]      retire_insn,
   output logic [RW-1:0]      retire_dst,
   output logic               retire_dst_en
);

   localparam int SW      = NSRC * RW;
   localparam int OFF_SEN = 0;
   localparam int OFF_SRC = OFF_SEN + NSRC;
   localparam int OFF_DEN = OFF_SRC + SW;
   localparam int OFF_DST = OFF_DEN + 1;
   localparam int OFF_INS = OFF_DST + RW;
   localparam int PW      = OFF_INS + IW;
   localparam int NREG    = NUM_REG_STAGES;
   localparam int IX_DEC  = STG_DECODE - 1;
   localparam int IX_ISS  = STG_ISSUE - 1;
   localparam int IX_EXE  = STG_EXEC - 1;

   if (IW < 1) begin : g_bad_iw
      $error("ioc_pipe_ctrl: IW must be at least 1");
   end
   if (RW < 1) begin : g_bad_rw
      $error("ioc_pipe_ctrl: RW must be at least 1");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("ioc_pipe_ctrl: NSRC must be at least 1");
   end
   if (NREG != 3) begin : g_bad_depth
      $error("ioc_pipe_ctrl: stage map expects three registered stages");
   end

   logic          accept;
   logic          hazard;
   logic          dec_hold;
   logic [PW-1:0] f_pay;
   logic          vld [NREG];
   logic [PW-1:0] pay [NREG];
   logic          d_vld, i_vld, e_vld;
   logic [PW-1:0] d_pay;

   assign f_pay  = {fetch_insn, fetch_dst, fetch_dst_en, fetch_src, fetch_src_en};
   assign accept = fetch_valid && fetch_ready;

   for (genvar s = 0; s < NREG; s++) begin : g_stg
      logic          in_v;
      logic [PW-1:0] in_p;
      logic          h;
      if (s == IX_DEC) begin : g_dec
         assign in_v = accept;
         assign in_p = f_pay;
         assign h    = dec_hold;
      end else if (s == IX_ISS) begin : g_iss
         assign in_v = vld[s-1] && !dec_hold;
         assign in_p = pay[s-1];
         assign h    = 1'b0;
      end else begin : g_fwd
         assign in_v = vld[s-1];
         assign in_p = pay[s-1];
         assign h    = 1'b0;
      end
      ioc_stage_reg #(.W(PW)) u_reg (
         .clk      (clk),
         .rst_n    (rst_n),
         .hold     (h),
         .in_vld   (in_v),
         .in_data  (in_p),
         .out_vld  (vld[s]),
         .out_data (pay[s])
      );
   end

   assign d_vld = vld[IX_DEC];
   assign i_vld = vld[IX_ISS];
   assign e_vld = vld[IX_EXE];
   assign d_pay = pay[IX_DEC];

   ioc_hazard #(.RW(RW), .NSRC(NSRC)) u_haz (
      .cons_vld    (d_vld),
      .cons_src    (d_pay[OFF_SRC +: SW]),
      .cons_src_en (d_pay[OFF_SEN +: NSRC]),
      .prod_vld    (i_vld),
      .prod_dst    (pay[IX_ISS][OFF_DST +: RW]),
      .prod_dst_en (pay[IX_ISS][OFF_DEN]),
      .hit         (hazard)
   );

   ioc_stall_ctrl u_stall (
      .clk         (clk),
      .rst_n       (rst_n),
      .hazard      (hazard),
      .dec_hold    (dec_hold),
      .front_stall (stall)
   );

   assign fetch_ready = !stall;

   assign occupancy[STG_FETCH]  = accept;
   assign occupancy[STG_DECODE] = d_vld;
   assign occupancy[STG_ISSUE]  = i_vld;
   assign occupancy[STG_EXEC]   = e_vld;

   assign retire_valid  = e_vld;
   assign retire_insn   = pay[IX_EXE][OFF_INS +: IW];
   assign retire_dst    = pay[IX_EXE][OFF_DST +: RW];
   assign retire_dst_en = pay[IX_EXE][OFF_DEN];

   logic [OFF_DEN-1:0] unused_exec_src;
   assign unused_exec_src = pay[IX_EXE][OFF_DEN-1:0];

endmodule

// File: rtl/ioc_pipe_chk.sv
module ioc_pipe_chk #(
   parameter int PW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_valid,
   input logic          fetch_ready,
   input logic          stall,
   input logic          dec_hold,
   input logic          d_vld,
   input logic [PW-1:0] d_pay,
   input logic          i_vld,
   input logic          e_vld
);

   // R2: an accepted instruction is in decode next cycle
   assert_accept_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_ready) |=> d_vld);

   // R2: execute takes whatever issue held the cycle before
   assert_issue_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      i_vld |=> e_vld);

   assert_exec_only_from_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !i_vld |=> !e_vld);

   // R4: no hazard without an instruction in issue
   assert_hazard_needs_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !i_vld |-> !dec_hold);

   // R5: decode holds the same instruction across a hazard
   assert_decode_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hold |=> (d_vld && $stable(d_pay)));

   // R5: stall extends one cycle beyond the hazard
   assert_stall_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hold |=> stall);

   // R6: issue becomes a bubble after a hazard
   assert_issue_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hold |=> !i_vld);

   // R6: the instruction in issue during a hazard moves on to execute
   assert_issue_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hold && i_vld) |=> e_vld);

endmodule

bind ioc_pipe_ctrl ioc_pipe_chk #(.PW(PW)) u_ioc_pipe_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .fetch_ready (fetch_ready),
   .stall       (stall),
   .dec_hold    (dec_hold),
   .d_vld       (d_vld),
   .d_pay       (d_pay),
   .i_vld       (i_vld),
   .e_vld       (e_vld)
);

// File: tb/test_ioc_pipe_ctrl.sv
`timescale 1ns/1ps
module test_ioc_pipe_ctrl;

   localparam int IW = 32;
   localparam int RW = 5;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_valid = 1'b0;
   logic          fetch_ready;
   logic [IW-1:0] fetch_insn = '0;
   logic [RW-1:0] fetch_dst = '0;
   logic          fetch_dst_en = 1'b0;
   logic [NS*RW-1:0] fetch_src = '0;
   logic [NS-1:0] fetch_src_en = '0;
   logic          stall;
   logic [3:0]    occupancy;
   logic          retire_valid;
   logic [IW-1:0] retire_insn;
   logic [RW-1:0] retire_dst;
   logic          retire_dst_en;

   always #2 clk = ~clk;

   ioc_pipe_ctrl #(.IW(IW), .RW(RW), .NSRC(NS)) i_ioc_pipe_ctrl (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
      .fetch_insn(fetch_insn), .fetch_dst(fetch_dst), .fetch_dst_en(fetch_dst_en),
      .fetch_src(fetch_src), .fetch_src_en(fetch_src_en),
      .stall(stall), .occupancy(occupancy),
      .retire_valid(retire_valid), .retire_insn(retire_insn),
      .retire_dst(retire_dst), .retire_dst_en(retire_dst_en)
   );

   typedef struct {
      logic [IW-1:0] insn;
      logic [RW-1:0] dst;
      logic          den;
      int            cyc;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    n_checks = 0;
   int    n_fail = 0;
   int    ex_c0 = -100;
   int    last_acc = -100;
   logic [RW-1:0] last_dst = '0;
   logic  last_den = 1'b0;
   bit    done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   // Driver: offers one instruction, waits for acceptance, predicts retire cycle.
   task automatic send(input logic [IW-1:0] insn, input logic [RW-1:0] dst,
                       input logic den, input logic [RW-1:0] s0, input logic e0,
                       input logic [RW-1:0] s1, input logic e1, output int acc);
      item_t it;
      bit dep;
      fetch_valid  = 1'b1;
      fetch_insn   = insn;
      fetch_dst    = dst;
      fetch_dst_en = den;
      fetch_src    = {s1, s0};
      fetch_src_en = {e1, e0};
      #1;
      while (!fetch_ready) begin
         @(negedge clk);
         #1;
      end
      acc = cyc;
      dep = (last_acc == acc - 1) && last_den &&
            ((e0 && s0 == last_dst) || (e1 && s1 == last_dst));
      it.insn = insn;
      it.dst  = dst;
      it.den  = den;
      it.cyc  = acc + 3 + (dep ? 1 : 0);
      sb.push_back(it);
      last_acc = acc;
      last_dst = dst;
      last_den = den;
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      fetch_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: scoreboard pops and compares every retire; example timing probes.
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (retire_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R3", "retire with empty scoreboard", retire_insn, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(retire_insn == it.insn, "R3", "retire order word", retire_insn, it.insn);
               check(retire_dst == it.dst && retire_dst_en == it.den, "R2",
                     "retire dst tag", {retire_dst_en, retire_dst}, {it.den, it.dst});
               check(cyc == it.cyc, "R7", "retire cycle", cyc, it.cyc);
            end
         end
         case (cyc - ex_c0)
            2: begin
               check(stall && !fetch_ready, "R5", "stall in hazard cycle", {stall, fetch_ready}, 2'b10);
               check(occupancy == 4'b0110, "R4", "occupancy hazard cycle", occupancy, 4'b0110);
            end
            3: begin
               check(stall && !fetch_ready, "R5", "stall tail cycle", {stall, fetch_ready}, 2'b10);
               check(occupancy == 4'b1010, "R6", "occupancy issue bubble", occupancy, 4'b1010);
            end
            4: begin
               check(!stall, "R7", "stall released", stall, 0);
               check(occupancy == 4'b0101, "R7", "occupancy after release", occupancy, 4'b0101);
            end
            default: ;
         endcase
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      report();
      $finish;
   end

   initial begin
      int a0, a1, a2, a3;
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      check(occupancy == 4'b0000 && !retire_valid, "R1", "empty during reset",
            {retire_valid, occupancy}, 0);
      check(!stall && fetch_ready, "R1", "ready during reset", {stall, fetch_ready}, 2'b01);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(occupancy == 4'b0000 && !stall, "R1", "empty after reset", {stall, occupancy}, 0);
      @(negedge clk);

      // R2 / R8: lone instruction followed by bubbles
      send(32'h1111_0001, 5'd9, 1'b1, 5'd1, 1'b1, 5'd2, 1'b1, a0);
      #1;
      check(occupancy == 4'b0010, "R8", "decode only", occupancy, 4'b0010);
      @(negedge clk);
      #1;
      check(occupancy == 4'b0100, "R8", "bubble behind issue", occupancy, 4'b0100);
      idle(4);

      // R3: independent back-to-back stream
      for (int k = 0; k < 6; k++) begin
         send(32'h2222_0000 + k, 5'(k + 10), 1'b1, 5'(k), 1'b1, 5'd0, 1'b0, a1);
         if (k > 0) check(a1 == a0 + 1, "R3", "consecutive acceptance", a1, a0 + 1);
         a0 = a1;
      end
      idle(5);

      // R4 R5 R6 R7: producer, consumer, follower
      send(32'h3000_0003, 5'd3, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, a0);
      ex_c0 = a0;
      send(32'h3000_0004, 5'd0, 1'b0, 5'd31, 1'b0, 5'd3, 1'b1, a1);
      send(32'h3000_0005, 5'd1, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0, a2);
      check(a1 == a0 + 1, "R7", "consumer accepted next cycle", a1, a0 + 1);
      check(a2 == a0 + 4, "R7", "follower accepted in cycle 5", a2, a0 + 4);
      idle(6);

      // R9: dependency two apart
      send(32'h4000_0001, 5'd7, 1'b1, 5'd1, 1'b1, 5'd0, 1'b0, a0);
      send(32'h4000_0002, 5'd8, 1'b1, 5'd2, 1'b1, 5'd0, 1'b0, a1);
      send(32'h4000_0003, 5'd6, 1'b1, 5'd7, 1'b1, 5'd7, 1'b1, a2);
      send(32'h4000_0004, 5'd5, 1'b1, 5'd9, 1'b1, 5'd0, 1'b0, a3);
      check(a3 == a0 + 3, "R9", "no stall at distance two", a3, a0 + 3);
      idle(5);

      // R10: matching tags with enables low
      send(32'h5000_0001, 5'd12, 1'b0, 5'd1, 1'b1, 5'd0, 1'b0, a0);
      send(32'h5000_0002, 5'd13, 1'b1, 5'd12, 1'b1, 5'd12, 1'b1, a1);
      send(32'h5000_0003, 5'd14, 1'b1, 5'd13, 1'b0, 5'd2, 1'b1, a2);
      send(32'h5000_0004, 5'd15, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0, a3);
      check(a3 == a0 + 3, "R10", "disabled tags never stall", a3, a0 + 3);
      idle(6);

      // R4: second source port alone creates a hazard
      send(32'h6000_0001, 5'd20, 1'b1, 5'd1, 1'b1, 5'd0, 1'b0, a0);
      send(32'h6000_0002, 5'd21, 1'b1, 5'd2, 1'b0, 5'd20, 1'b1, a1);
      send(32'h6000_0003, 5'd22, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, a2);
      check(a2 == a1 + 3, "R4", "second source hazard", a2, a1 + 3);
      idle(8);

      check(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
      done = 1;
      report();
      $finish;
   end

endmodule